// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel. It copies data between a fixed device-side address and a memory buffer over a single memory-master port that uses a request/grant handshake. A start pulse launches a job in one of two modes. In the direct mode the channel takes a descriptor from its configuration inputs and runs it. In the linked mode the channel reads a chain of four-word descriptors from memory and follows the links until a descriptor marks the end of the chain.

Each descriptor holds four 32-bit words: a device address, a memory address, a size word and a link word. The size word carries an element-width code and a byte count. The link word carries the address of the next descriptor and two control bits. One control bit chooses between ending the chain and following the link. The other asks for an interrupt when the descriptor completes.

The controller is a state machine with six states:
- `S_IDLE` moves to `S_FETCH` on a linked start, or to `S_CHECK` on a direct start.
- `S_FETCH` moves to `S_CHECK` after the fourth word is granted.
- `S_CHECK` moves to `S_IDLE` on an illegal size word, to `S_LINK` on a zero count, and to `S_RD` otherwise.
- `S_RD` moves to `S_WR` on a grant.
- `S_WR` moves back to `S_RD`, or to `S_LINK` after the last element.
- `S_LINK` moves to `S_FETCH` to follow a link, or to `S_IDLE` at the end of the chain.
- Every state moves to `S_IDLE` whenever the mode input says disabled.

Top module: `dma_chain_channel`

## Requirements
- R1: A start pulse with mode 2 (direct) copies the configuration descriptor and begins with a data read. No descriptor word is read from memory.
- R2: A start pulse with mode 1 (linked) reads four words at the link-input address with bits [1:0] cleared, at offsets 0, 4, 8 and 12. These words are the device address, memory address, size word and link word, in that order.
- R3: Size-word bits [13:12] give the element width: 3 is 1 byte, 2 is 2 bytes and 0 is 4 bytes. `msize_o` reports 0, 1 or 2 for these widths. The count is in bytes. The number of elements is the count divided by the width, rounded up, so a count of 0 moves no data. Both addresses advance by the width after every element.
- R4: With `dir_i`=1 each element is read from the memory address and written to the device address. With `dir_i`=0 it goes the other way. The write data equals the data that was read.
- R5: Link-word bit 1 set means follow: in linked mode the next descriptor is fetched from link bits [31:2] with bits [1:0] cleared. Bit 1 clear ends the chain, and the channel returns to idle.
- R6: `done_o` pulses for one cycle after each descriptor's last element, or straight after a zero-count descriptor. `irq_o` is high in that same cycle only when link bit 0 is set.
- R7: `state_o` reads 0 when idle, 1 while reading a descriptor, 2 while decoding or linking, and 3 during data reads and writes. It reads 0 after reset.
- R8: Width code 1 is reserved. It raises a one-cycle `err_o` pulse, returns the channel to idle, and moves no data and gives no `done_o`.
- R9: The count field is size bits [10:0]. A count above 0x3FF for 1- or 2-byte width, or above 0x7FF for 4-byte width, is handled as in R8. A count of 0x7FF at 4-byte width runs normally.
- R10: Mode 0 or 3 (disabled) aborts a job. From the next cycle the state is idle, no request is made, and no done pulse follows.
- R11: In direct mode the follow bit is ignored: the channel stops after the single descriptor.
- R12: A request keeps its address, direction and data until it is granted. A start pulse while busy or while disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 2 | 0/3 disabled, 1 linked, 2 direct |
| dir_i | input | 1 | 1: memory to device, 0: device to memory (sampled at start) |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cfg_dev_i | input | 32 | Direct-mode device address |
| cfg_mem_i | input | 32 | Direct-mode memory address |
| cfg_size_i | input | 32 | Direct-mode size word |
| cfg_link_i | input | 32 | Direct-mode link word, or first descriptor address in linked mode |
| state_o | output | 2 | Engine state code |
| done_o | output | 1 | Descriptor-complete pulse |
| irq_o | output | 1 | Interrupt request, only together with done_o |
| err_o | output | 1 | Illegal size-word pulse |
| mreq_o | output | 1 | Memory request |
| mwe_o | output | 1 | Request is a write |
| maddr_o | output | 32 | Request address |
| msize_o | output | 2 | Access size: 0 byte, 1 halfword, 2 word |
| mwdata_o | output | 32 | Write data |
| mgnt_i | input | 1 | Grant; the access completes in this cycle |
| mrdata_i | input | 32 | Read data, valid with the grant |

## Verification
The hardest case to reach from the ports is an abort while a request is outstanding. The bench creates it by holding off grants, so the channel waits in a data read. It then drops the mode to disabled and checks that the request disappears and no completion follows. Chains that mix widths, odd byte counts and a zero count are run against a scoreboard. The scoreboard checks every granted access in order, including the state code reported at each access. A start pulse sent mid-transfer with altered configuration shows that the access stream does not change.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_CHAIN   = 2'd1,
        MODE_ONESHOT = 2'd2,
        MODE_RSVD    = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DESC = 2'd1,
        ST_WAIT = 2'd2,
        ST_DATA = 2'd3
    } chan_state_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHECK,
        S_RD,
        S_WR,
        S_LINK
    } fsm_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

endpackage

// File: rtl/dma_size_decode.sv
module dma_size_decode
    import dma_chan_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int NARROW_MAX = 'h3FF,
    parameter int WIDE_MAX   = 'h7FF
) (
    input  logic [1:0]       wcode_i,
    input  logic [CNT_W-1:0] count_i,
    output xfer_size_e       size_o,
    output logic [2:0]       step_o,
    output logic             bad_o
);

    localparam logic [CNT_W-1:0] LIM_NARROW = CNT_W'(NARROW_MAX);
    localparam logic [CNT_W-1:0] LIM_WIDE   = CNT_W'(WIDE_MAX);

    always_comb begin
        size_o = SZ_WORD;
        step_o = 3'd4;
        bad_o  = 1'b0;
        unique case (wcode_i)
            2'd3: begin
                size_o = SZ_BYTE;
                step_o = 3'd1;
                bad_o  = count_i > LIM_NARROW;
            end
            2'd2: begin
                size_o = SZ_HALF;
                step_o = 3'd2;
                bad_o  = count_i > LIM_NARROW;
            end
            2'd0: begin
                size_o = SZ_WORD;
                step_o = 3'd4;
                bad_o  = count_i > LIM_WIDE;
            end
            default: begin
                bad_o  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr
    import dma_chan_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] dev_i,
    input  logic [WORD_W-1:0] mem_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              step_i,
    input  logic [2:0]        step_bytes_i,
    output logic [WORD_W-1:0] dev_o,
    output logic [WORD_W-1:0] mem_o,
    output logic              last_o
);

    logic [WORD_W-1:0] dev_q, mem_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CNT_W-1:0]  step_cnt;

    assign step_cnt = CNT_W'(step_bytes_i);
    assign last_o   = rem_q <= step_cnt;
    assign dev_o    = dev_q;
    assign mem_o    = mem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q <= '0;
            mem_q <= '0;
            rem_q <= '0;
        end else if (load_i) begin
            dev_q <= dev_i;
            mem_q <= mem_i;
            rem_q <= count_i;
        end else if (step_i) begin
            dev_q <= dev_q + WORD_W'(step_bytes_i);
            mem_q <= mem_q + WORD_W'(step_bytes_i);
            rem_q <= last_o ? '0 : rem_q - step_cnt;
        end
    end

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> (mem_q == $past(mem_q) + WORD_W'($past(step_bytes_i)))
                             && (dev_q == $past(dev_q) + WORD_W'($past(step_bytes_i)))); // R3

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dma_chan_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int NARROW_MAX = 'h3FF,
    parameter int WIDE_MAX   = 'h7FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              dir_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cfg_dev_i,
    input  logic [WORD_W-1:0] cfg_mem_i,
    input  logic [WORD_W-1:0] cfg_size_i,
    input  logic [WORD_W-1:0] cfg_link_i,
    output logic [1:0]        state_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              mreq_o,
    output logic              mwe_o,
    output logic [WORD_W-1:0] maddr_o,
    output logic [1:0]        msize_o,
    output logic [WORD_W-1:0] mwdata_o,
    input  logic              mgnt_i,
    input  logic [WORD_W-1:0] mrdata_i
);

    localparam int DESC_WORDS = 4;
    localparam int IDX_W      = $clog2(DESC_WORDS);

    fsm_e              cur, nxt;
    logic              mode_off, xfer;
    logic [WORD_W-1:0] d_dev, d_mem, d_link, ptr, elem_q;
    logic [1:0]        d_wcode;
    logic [CNT_W-1:0]  d_cnt;
    logic [IDX_W-1:0]  idx;
    logic              oneshot_q, dir_q;
    logic              done_q, irq_q, err_q;
    xfer_size_e        dec_size;
    logic [2:0]        dec_step;
    logic              dec_bad, last_elem;
    logic [WORD_W-1:0] run_dev, run_mem;
    logic              unused_size_bits;

    assign unused_size_bits = ^{cfg_size_i[WORD_W-1:14], cfg_size_i[11:CNT_W]};
    assign mode_off = (mode_i == MODE_OFF) || (mode_i == MODE_RSVD);
    assign xfer     = mreq_o && mgnt_i;

    dma_size_decode #(
        .CNT_W      (CNT_W),
        .NARROW_MAX (NARROW_MAX),
        .WIDE_MAX   (WIDE_MAX)
    ) u_decode (
        .wcode_i (d_wcode),
        .count_i (d_cnt),
        .size_o  (dec_size),
        .step_o  (dec_step),
        .bad_o   (dec_bad)
    );

    dma_xfer_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (cur == S_CHECK),
        .dev_i        (d_dev),
        .mem_i        (d_mem),
        .count_i      (d_cnt),
        .step_i       ((cur == S_WR) && xfer),
        .step_bytes_i (dec_step),
        .dev_o        (run_dev),
        .mem_o        (run_mem),
        .last_o       (last_elem)
    );

    // Next-state logic
    always_comb begin
        nxt = cur;
        if (mode_off) begin
            nxt = S_IDLE;
        end else begin
            unique case (cur)
                S_IDLE: begin
                    if (start_i && mode_i == MODE_CHAIN)        nxt = S_FETCH;
                    else if (start_i && mode_i == MODE_ONESHOT) nxt = S_CHECK;
                end
                S_FETCH: if (xfer && idx == IDX_W'(DESC_WORDS - 1)) nxt = S_CHECK;
                S_CHECK: begin
                    if (dec_bad)          nxt = S_IDLE;
                    else if (d_cnt == '0) nxt = S_LINK;
                    else                  nxt = S_RD;
                end
                S_RD:    if (xfer) nxt = S_WR;
                S_WR:    if (xfer) nxt = last_elem ? S_LINK : S_RD;
                S_LINK:  nxt = (!oneshot_q && d_link[1]) ? S_FETCH : S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= S_IDLE;
        else        cur <= nxt;
    end

    // Descriptor and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_dev     <= '0;
            d_mem     <= '0;
            d_wcode   <= '0;
            d_cnt     <= '0;
            d_link    <= '0;
            ptr       <= '0;
            idx       <= '0;
            elem_q    <= '0;
            oneshot_q <= 1'b0;
            dir_q     <= 1'b0;
        end else begin
            if (cur == S_IDLE && start_i && !mode_off) begin
                oneshot_q <= (mode_i == MODE_ONESHOT);
                dir_q     <= dir_i;
                ptr       <= {cfg_link_i[WORD_W-1:2], 2'b00};
                idx       <= '0;
                if (mode_i == MODE_ONESHOT) begin
                    d_dev   <= cfg_dev_i;
                    d_mem   <= cfg_mem_i;
                    d_wcode <= cfg_size_i[13:12];
                    d_cnt   <= cfg_size_i[CNT_W-1:0];
                    d_link  <= cfg_link_i;
                end
            end
            if (cur == S_FETCH && xfer) begin
                unique case (idx)
                    2'd0: d_dev  <= mrdata_i;
                    2'd1: d_mem  <= mrdata_i;
                    2'd2: begin
                        d_wcode <= mrdata_i[13:12];
                        d_cnt   <= mrdata_i[CNT_W-1:0];
                    end
                    default: d_link <= mrdata_i;
                endcase
                idx <= idx + 1'b1;
            end
            if (cur == S_LINK) begin
                ptr <= {d_link[WORD_W-1:2], 2'b00};
                idx <= '0;
            end
            if (cur == S_RD && xfer) elem_q <= mrdata_i;
        end
    end

    // Registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= !mode_off && cur == S_LINK;
            irq_q  <= !mode_off && cur == S_LINK && d_link[0];
            err_q  <= !mode_off && cur == S_CHECK && dec_bad;
        end
    end

    assign done_o = done_q;
    assign irq_o  = irq_q;
    assign err_o  = err_q;

    // Memory port and state report
    always_comb begin
        mreq_o   = 1'b0;
        mwe_o    = 1'b0;
        maddr_o  = '0;
        msize_o  = SZ_WORD;
        mwdata_o = '0;
        state_o  = ST_IDLE;
        unique case (cur)
            S_FETCH: begin
                mreq_o  = 1'b1;
                maddr_o = ptr + WORD_W'({idx, 2'b00});
                state_o = ST_DESC;
            end
            S_CHECK, S_LINK: state_o = ST_WAIT;
            S_RD: begin
                mreq_o  = 1'b1;
                maddr_o = dir_q ? run_mem : run_dev;
                msize_o = dec_size;
                state_o = ST_DATA;
            end
            S_WR: begin
                mreq_o   = 1'b1;
                mwe_o    = 1'b1;
                maddr_o  = dir_q ? run_dev : run_mem;
                msize_o  = dec_size;
                mwdata_o = elem_q;
                state_o  = ST_DATA;
            end
            default: state_o = ST_IDLE;
        endcase
    end

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_DESC) |-> (maddr_o[1:0] == 2'b00 && !mwe_o)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE) |-> !mreq_o); // R7
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o); // R6
    AST_DONE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_o) == ST_WAIT)); // R6
    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (state_o == ST_IDLE && !done_o)); // R8
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_off |=> (state_o == ST_IDLE && !mreq_o && !done_o)); // R10
    AST_ONESHOT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_q && cur != S_IDLE) |-> (state_o != ST_DESC)); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_o && !mgnt_i && !mode_off) |=> (mreq_o && $stable(maddr_o)
                                            && $stable(mwe_o) && $stable(mwdata_o))); // R12

endmodule

// File: tb/dma_chain_channel_bench.sv
module dma_chain_channel_bench;
    import dma_chan_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, dir, start, mgnt;
    logic [1:0]  mode;
    logic [31:0] cfg_dev, cfg_mem, cfg_size, cfg_link, mrdata;
    logic [1:0]  state_o, msize_o;
    logic        done_o, irq_o, err_o, mreq_o, mwe_o;
    logic [31:0] maddr_o, mwdata_o;

    dma_chain_channel u_dma_chain_channel (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .dir_i(dir), .start_i(start),
        .cfg_dev_i(cfg_dev), .cfg_mem_i(cfg_mem), .cfg_size_i(cfg_size), .cfg_link_i(cfg_link),
        .state_o(state_o), .done_o(done_o), .irq_o(irq_o), .err_o(err_o),
        .mreq_o(mreq_o), .mwe_o(mwe_o), .maddr_o(maddr_o), .msize_o(msize_o),
        .mwdata_o(mwdata_o), .mgnt_i(mgnt), .mrdata_i(mrdata)
    );

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        logic [1:0]  st;
        string       req;
    } acc_t;

    acc_t        exp_acc[$];
    logic [1:0]  exp_evt[$];   // 0 done, 1 done+irq, 2 error
    logic [31:0] dmem[logic [31:0]];
    int          n_run = 0, n_fail = 0, gcnt = 0;
    bit          gnt_en = 1'b1;
    acc_t        ce;
    logic [1:0]  got_e, want_e;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (dmem.exists(a)) return dmem[a];
        return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                            input logic [1:0] sz, input logic [1:0] st, input string req);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.size = sz; e.st = st; e.req = req;
        exp_acc.push_back(e);
    endtask

    task automatic push_fetch(input logic [31:0] base);
        for (int i = 0; i < 4; i++) push_acc(1'b0, base + 32'(4 * i), 32'h0, 2'd2, 2'd1, "R2");
    endtask

    task automatic push_elems(input logic d, input logic [31:0] dv, input logic [31:0] mm,
                              input logic [31:0] sw, input string req);
        int w, rem;
        logic [1:0] sz;
        logic [31:0] src, dst;
        w  = (sw[13:12] == 2'd3) ? 1 : (sw[13:12] == 2'd2) ? 2 : 4;
        sz = (w == 1) ? 2'd0 : (w == 2) ? 2'd1 : 2'd2;
        rem = int'(sw[10:0]);
        while (rem > 0) begin
            src = d ? mm : dv;
            dst = d ? dv : mm;
            push_acc(1'b0, src, 32'h0, sz, 2'd3, req);
            push_acc(1'b1, dst, rd_word(src), sz, 2'd3, req);
            dv = dv + 32'(w);
            mm = mm + 32'(w);
            rem = (rem > w) ? rem - w : 0;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!(exp_acc.size() == 0 && exp_evt.size() == 0 && state_o == 2'd0) && guard < 20000);
        repeat (3) @(negedge clk);
        chk(exp_acc.size() == 0 && exp_evt.size() == 0, req, "pending expectations",
            64'(exp_acc.size() + exp_evt.size()), 64'd0);
    endtask

    task automatic oneshot(input logic d, input logic [31:0] dv, input logic [31:0] mm,
                           input logic [31:0] sw, input logic [31:0] lk);
        cfg_dev = dv; cfg_mem = mm; cfg_size = sw; cfg_link = lk; dir = d; mode = 2'd2;
    endtask

    // Monitor: grant model and scoreboard comparison
    always @(negedge clk) begin
        if (!rst_n) begin
            mgnt = 1'b0;
        end else begin
            if (done_o || err_o) begin
                got_e = err_o ? 2'd2 : (irq_o ? 2'd1 : 2'd0);
                if (exp_evt.size() == 0) begin
                    chk(1'b0, "R6", "unexpected event", 64'(got_e), 64'd3);
                end else begin
                    want_e = exp_evt.pop_front();
                    chk(got_e == want_e, "R6", "event code", 64'(got_e), 64'(want_e));
                end
            end
            gcnt++;
            if (mreq_o && gnt_en && (gcnt % 3 != 1)) begin
                mgnt   = 1'b1;
                mrdata = rd_word(maddr_o);
                if (exp_acc.size() == 0) begin
                    chk(1'b0, "R12", "unexpected access", 64'(maddr_o), 64'd0);
                end else begin
                    ce = exp_acc.pop_front();
                    chk({mwe_o, msize_o, state_o, maddr_o} == {ce.we, ce.size, ce.st, ce.addr},
                        ce.req, "access we/size/state/addr",
                        64'({mwe_o, msize_o, state_o, maddr_o}), 64'({ce.we, ce.size, ce.st, ce.addr}));
                    if (ce.we)
                        chk(mwdata_o == ce.data, "R4", "write data", 64'(mwdata_o), 64'(ce.data));
                end
            end else begin
                mgnt = 1'b0;
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL R12 watchdog expired actual=hung expected=idle");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; dir = 1'b0; start = 1'b0; mrdata = '0;
        cfg_dev = '0; cfg_mem = '0; cfg_size = '0; cfg_link = '0;
        repeat (3) @(negedge clk);
        chk(state_o == 2'd0 && !mreq_o && !done_o && !err_o && !irq_o, "R7", "reset outputs",
            64'({state_o, mreq_o, done_o, err_o, irq_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3 R4: direct mode, 4-byte elements, memory to device, end with irq
        oneshot(1'b1, 32'h4000_0010, 32'h0001_0000, 32'h0000_000C, 32'h0000_0001);
        push_elems(1'b1, cfg_dev, cfg_mem, cfg_size, "R1");
        exp_evt.push_back(2'd1);
        pulse_start();
        wait_idle("R1");

        // R11: direct mode, 1-byte elements, device to memory, follow bit ignored
        oneshot(1'b0, 32'h4000_0003, 32'h0001_1001, 32'h0000_3003, 32'h0002_0003);
        push_elems(1'b0, cfg_dev, cfg_mem, cfg_size, "R3");
        exp_evt.push_back(2'd1);
        pulse_start();
        wait_idle("R11");
        chk(state_o == 2'd0, "R11", "idle after direct job", 64'(state_o), 64'd0);

        // R2 R5: linked chain of two descriptors, 2-byte odd count then 4-byte
        dmem[32'h8000] = 32'h4000_0020; dmem[32'h8004] = 32'h0002_0001;
        dmem[32'h8008] = 32'h0000_2005; dmem[32'h800C] = 32'h0000_8102;
        dmem[32'h8100] = 32'h4000_0040; dmem[32'h8104] = 32'h0003_0000;
        dmem[32'h8108] = 32'h0000_0008; dmem[32'h810C] = 32'h0000_0000;
        push_fetch(32'h8000);
        push_elems(1'b1, 32'h4000_0020, 32'h0002_0001, 32'h0000_2005, "R5");
        exp_evt.push_back(2'd0);
        push_fetch(32'h8100);
        push_elems(1'b1, 32'h4000_0040, 32'h0003_0000, 32'h0000_0008, "R5");
        exp_evt.push_back(2'd0);
        dir = 1'b1; mode = 2'd1; cfg_link = 32'h0000_8003;
        pulse_start();
        wait_idle("R5");

        // R3: zero-count descriptor in a chain, end with irq
        dmem[32'h8200] = 32'h4000_0060; dmem[32'h8204] = 32'h0004_0000;
        dmem[32'h8208] = 32'h0000_0000; dmem[32'h820C] = 32'h0000_0001;
        push_fetch(32'h8200);
        exp_evt.push_back(2'd1);
        cfg_link = 32'h0000_8200;
        pulse_start();
        wait_idle("R3");

        // R8: reserved width code, direct and linked
        oneshot(1'b1, 32'h4000_0080, 32'h0005_0000, 32'h0000_1004, 32'h0000_0001);
        exp_evt.push_back(2'd2);
        pulse_start();
        wait_idle("R8");
        dmem[32'h8300] = 32'h4000_0090; dmem[32'h8304] = 32'h0005_1000;
        dmem[32'h8308] = 32'h0000_1004; dmem[32'h830C] = 32'h0000_0003;
        push_fetch(32'h8300);
        exp_evt.push_back(2'd2);
        mode = 2'd1; cfg_link = 32'h0000_8300;
        pulse_start();
        wait_idle("R8");

        // R9: count limits
        oneshot(1'b1, 32'h4000_00A0, 32'h0006_0000, 32'h0000_3400, 32'h0000_0000);
        exp_evt.push_back(2'd2);
        pulse_start();
        wait_idle("R9");
        oneshot(1'b1, 32'h4000_00A0, 32'h0006_0000, 32'h0000_27FF, 32'h0000_0000);
        exp_evt.push_back(2'd2);
        pulse_start();
        wait_idle("R9");
        oneshot(1'b0, 32'h4000_1000, 32'h0007_0000, 32'h0000_07FF, 32'h0000_0000);
        push_elems(1'b0, cfg_dev, cfg_mem, cfg_size, "R9");
        exp_evt.push_back(2'd0);
        pulse_start();
        wait_idle("R9");

        // R12: start while busy with changed configuration is ignored
        oneshot(1'b0, 32'h4000_2000, 32'h0008_0000, 32'h0000_0010, 32'h0000_0001);
        push_elems(1'b0, cfg_dev, cfg_mem, cfg_size, "R12");
        exp_evt.push_back(2'd1);
        pulse_start();
        repeat (3) @(negedge clk);
        cfg_dev = 32'h4000_3000; cfg_mem = 32'h0009_0000; cfg_size = 32'h0000_0004;
        pulse_start();
        wait_idle("R12");

        // R10: abort while a read waits for its grant
        gnt_en = 1'b0;
        oneshot(1'b1, 32'h4000_4000, 32'h000A_0000, 32'h0000_0008, 32'h0000_0001);
        pulse_start();
        repeat (3) @(negedge clk);
        chk(state_o == 2'd3 && mreq_o, "R7", "data state while waiting",
            64'({state_o, mreq_o}), 64'({2'd3, 1'b1}));
        mode = 2'd0;
        @(negedge clk);
        chk(state_o == 2'd0 && !mreq_o, "R10", "abort to idle", 64'({state_o, mreq_o}), 64'd0);
        gnt_en = 1'b1;
        repeat (10) @(negedge clk);
        chk(exp_evt.size() == 0 && state_o == 2'd0, "R10", "no completion after abort",
            64'({exp_evt.size(), state_o}), 64'd0);

        // R12: start while disabled does nothing
        mode = 2'd3;
        pulse_start();
        @(negedge clk);
        chk(state_o == 2'd0 && !mreq_o, "R12", "start while disabled", 64'({state_o, mreq_o}), 64'd0);

        // R1: channel usable again after abort
        oneshot(1'b1, 32'h4000_5000, 32'h000B_0002, 32'h0000_2004, 32'h0000_0000);
        push_elems(1'b1, cfg_dev, cfg_mem, cfg_size, "R1");
        exp_evt.push_back(2'd0);
        pulse_start();
        wait_idle("R1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule